// File: doc/BRIEF.md
# Multi-Mode Two-Output PWM Generator

This block drives two gate signals, A and B, from one free-running period counter. The counter runs from 0 up to a programmed period value and then wraps to 0. The counter value is compared against edges that are derived from a duty value, two dead-time values and a phase offset. The block supports four waveform shapes. In normal mode a trailing pulse on A is followed by B. Leading-edge mode is the same shape reversed in time. Triangular mode gives a single centred pulse on B. Multi mode gives two equal-width pulses, and the second pulse may wrap across the period end.

Each period has length `period + 1` clock cycles. A strobe marks cycle 0 of every period. Every setting is captured at the period start, so a pulse in progress never changes shape. When automatic switching is enabled, the duty value picks one of three mode selections: low, mid or high. Two threshold pairs with hysteresis control the choice, so a duty value near a switching point cannot make the mode oscillate.

Top module: `pwm_multimode`

## Requirements
- R1: While enabled, `pstart` is high exactly once every `period + 1` cycles. It marks counter value 0, and the counter steps by one per cycle up to `period`.
- R2: Mode encoding 0 (normal), with duty D, period length L = period+1 and counter value k:
  - A is high for k < D.
  - B is high for D + dead_lead <= k < L - dead_trail.
- R3: Mode encoding 1 (leading edge):
  - A is high for k >= L - D.
  - B is high for dead_lead <= k < L - D - dead_trail.
- R4: Mode encoding 2 (triangular): A stays low. B is high for S <= k < S + D, where S = floor((L - D) / 2).
- R5: Mode encoding 3 (multi):
  - A is high for k < D.
  - B is high for D cycles starting at k = phase_ofs, wrapping past the period end into the next period.
  - When D = L, both outputs stay high.
- R6: Out-of-range values are clamped:
  - A duty value above L is treated as L.
  - A phase offset above `period` is treated as `period`.
  - An edge whose computed position is negative is placed at 0.
- R7: Period, duty, dead times, offset and the selected mode are captured only on the cycle where the counter returns to 0. A duty change in mid-period does not alter the current pulse.
- R8: With `auto_en` high, the selection moves from low to mid only when duty > `th_lm_up`. It moves from mid back to low only when duty < `th_lm_dn`.
- R9: With `auto_en` high, the selection moves from mid to high only when duty > `th_mh_up`. It moves from high back to mid only when duty < `th_mh_dn`. The selection moves by at most one level per period.
- R10: With `auto_en` low, `mode_low` is always the mode used.
- R11: Enable behaviour:
  - While `en` is low, `pwm_a`, `pwm_b` and `pstart` are low and the counter is held at 0.
  - The clock edge that first sees `en` high starts a period.
- R12: After a synchronous active-low reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| auto_en | input | 1 | Enables duty-driven selection among the three modes |
| period | input | CW | Last counter value of the period |
| duty | input | CW | Pulse width in cycles |
| dead_lead | input | CW | Gap from A turning off to B turning on |
| dead_trail | input | CW | Gap from B turning off to A turning on |
| phase_ofs | input | CW | Start of B in multi mode |
| mode_low | input | 2 | Mode used at the low level (0 normal, 1 leading, 2 triangular, 3 multi) |
| mode_mid | input | 2 | Mode used at the mid level |
| mode_high | input | 2 | Mode used at the high level |
| th_lm_up | input | CW | Low-to-mid rising threshold |
| th_lm_dn | input | CW | Mid-to-low falling threshold |
| th_mh_up | input | CW | Mid-to-high rising threshold |
| th_mh_dn | input | CW | High-to-mid falling threshold |
| pwm_a | output | 1 | Gate drive A |
| pwm_b | output | 1 | Gate drive B |
| pstart | output | 1 | High on counter value 0 |

## Verification
The clock edge that sees `en` high, or that sees the counter at `period`, also loads the settings and sets the counter to 0. Therefore `pstart` and the first-cycle values of both outputs are valid at the falling edge after that clock edge. The outputs are combinational from registered state, so each later counter value k is visible k falling edges after the `pstart` sample. The bench samples at exactly those points. It changes duty, the mode selection or the thresholds only after a `pstart` sample, so they take effect at the following period start. The result of a level change is read at that next `pstart` sample.

// File: rtl/pwm_mm_pkg.sv
// Shared types for the multi-mode PWM generator.
// Assumes a 2-bit mode field whose encoding the bench also relies on.
package pwm_mm_pkg;
    typedef enum logic [1:0] {
        MD_NORMAL   = 2'd0,
        MD_LEADING  = 2'd1,
        MD_TRIANGLE = 2'd2,
        MD_MULTI    = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MID  = 2'd1,
        LV_HIGH = 2'd2
    } cfg_level_e;
endpackage

// File: rtl/pwm_cfg_sel.sv
// Hysteretic selection among three mode settings, driven by duty.
// Assumes th_*_dn <= th_*_up for each pair. The level only updates on load
// and moves at most one step per period.
module pwm_cfg_sel
    import pwm_mm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          auto_en,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] th_lm_up,
    input  logic [CW-1:0] th_lm_dn,
    input  logic [CW-1:0] th_mh_up,
    input  logic [CW-1:0] th_mh_dn,
    input  pwm_mode_e     mode_low,
    input  pwm_mode_e     mode_mid,
    input  pwm_mode_e     mode_high,
    output pwm_mode_e     mode_next
);
    cfg_level_e lvl_q, lvl_d;

    // Next level from the current level and the duty value.
    always_comb begin
        lvl_d = lvl_q;
        if (!auto_en) begin
            lvl_d = LV_LOW;
        end else begin
            case (lvl_q)
                LV_LOW:  if (duty > th_lm_up) lvl_d = LV_MID;
                LV_MID:  if (duty > th_mh_up) lvl_d = LV_HIGH;
                         else if (duty < th_lm_dn) lvl_d = LV_LOW;
                LV_HIGH: if (duty < th_mh_dn) lvl_d = LV_MID;
                default: lvl_d = LV_LOW;
            endcase
        end
    end

    // Mode used at the level that is about to be loaded.
    always_comb begin
        case (lvl_d)
            LV_MID:  mode_next = mode_mid;
            LV_HIGH: mode_next = mode_high;
            default: mode_next = mode_low;
        endcase
    end

    // Level register, updated only at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LV_LOW;
        else if (load) lvl_q <= lvl_d;
    end

    // R9
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LV_LOW) |=> (lvl_q != LV_HIGH));
    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lvl_q));
endmodule

// File: rtl/pwm_timebase.sv
// Period counter and period-start capture of all settings.
// Assumes the settings are static enough to be sampled once per period.
// Duty is clamped to the period length and the offset to the period value.
module pwm_timebase
    import pwm_mm_pkg::*;
#(
    parameter int CW = 8,
    localparam int W = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] dead_lead,
    input  logic [CW-1:0] dead_trail,
    input  logic [CW-1:0] phase_ofs,
    input  pwm_mode_e     mode_next,
    output logic          load,
    output logic          run_q,
    output logic [CW-1:0] cnt_q,
    output logic [W-1:0]  len_q,
    output logic [W-1:0]  duty_q,
    output logic [CW-1:0] dlead_q,
    output logic [CW-1:0] dtrail_q,
    output logic [CW-1:0] ofs_q,
    output pwm_mode_e     mode_q
);
    logic [CW-1:0] per_q;
    logic [W-1:0]  len_in, duty_in;

    // Start a period when starting up or when the counter wraps.
    assign load    = en && (!run_q || cnt_q == per_q);
    assign len_in  = {1'b0, period} + W'(1);
    assign duty_in = ({1'b0, duty} > len_in) ? len_in : {1'b0, duty};

    // Counter and settings capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            per_q    <= '0;
            len_q    <= W'(1);
            duty_q   <= '0;
            dlead_q  <= '0;
            dtrail_q <= '0;
            ofs_q    <= '0;
            mode_q   <= MD_NORMAL;
        end else if (!en) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q    <= 1'b1;
            cnt_q    <= '0;
            per_q    <= period;
            len_q    <= len_in;
            duty_q   <= duty_in;
            dlead_q  <= dead_lead;
            dtrail_q <= dead_trail;
            ofs_q    <= (phase_ofs > period) ? period : phase_ofs;
            mode_q   <= mode_next;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && cnt_q != per_q) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0 && !run_q));
    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(duty_q));
endmodule

// File: rtl/pwm_edges.sv
// Combinational edge placement for the four modes, from counter and settings.
// Assumes duty_q <= len_q and ofs_q < len_q. Negative edges saturate at 0.
module pwm_edges
    import pwm_mm_pkg::*;
#(
    parameter int CW = 8,
    localparam int W = CW + 1
) (
    input  pwm_mode_e     mode,
    input  logic [CW-1:0] cnt,
    input  logic [W-1:0]  len,
    input  logic [W-1:0]  duty,
    input  logic [CW-1:0] dlead,
    input  logic [CW-1:0] dtrail,
    input  logic [CW-1:0] ofs,
    output logic          a_raw,
    output logic          b_raw
);
    function automatic logic [W-1:0] sat_sub(input logic [W-1:0] x, input logic [W-1:0] y);
        return (x > y) ? x - y : '0;
    endfunction

    logic [W-1:0] c, nb_rise, nb_fall, la_rise, lb_fall, t_start, m_end;

    // Edge positions for every mode.
    always_comb begin
        c       = {1'b0, cnt};
        nb_rise = duty + {1'b0, dlead};
        nb_fall = sat_sub(len, {1'b0, dtrail});
        la_rise = len - duty;
        lb_fall = sat_sub(la_rise, {1'b0, dtrail});
        t_start = (len - duty) >> 1;
        m_end   = {1'b0, ofs} + duty;
    end

    // Output selection by mode.
    always_comb begin
        a_raw = 1'b0;
        b_raw = 1'b0;
        case (mode)
            MD_NORMAL: begin
                a_raw = c < duty;
                b_raw = (c >= nb_rise) && (c < nb_fall);
            end
            MD_LEADING: begin
                a_raw = (duty != '0) && (c >= la_rise);
                b_raw = (c >= {1'b0, dlead}) && (c < lb_fall);
            end
            MD_TRIANGLE: begin
                b_raw = (c >= t_start) && (c < t_start + duty);
            end
            default: begin
                a_raw = c < duty;
                if (m_end <= len) b_raw = (c >= {1'b0, ofs}) && (c < m_end);
                else              b_raw = (c >= {1'b0, ofs}) || (c < m_end - len);
            end
        endcase
    end
endmodule

// File: rtl/pwm_multimode.sv
// Top level: two-output multi-mode PWM with hysteretic automatic mode choice.
// Assumes a single clock. The outputs are combinational from registered state.
module pwm_multimode
    import pwm_mm_pkg::*;
#(
    parameter int CW = 8,
    localparam int W = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          auto_en,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] dead_lead,
    input  logic [CW-1:0] dead_trail,
    input  logic [CW-1:0] phase_ofs,
    input  logic [1:0]    mode_low,
    input  logic [1:0]    mode_mid,
    input  logic [1:0]    mode_high,
    input  logic [CW-1:0] th_lm_up,
    input  logic [CW-1:0] th_lm_dn,
    input  logic [CW-1:0] th_mh_up,
    input  logic [CW-1:0] th_mh_dn,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          pstart
);
    pwm_mode_e     mode_next, mode_q;
    logic          load, run_q, a_raw, b_raw;
    logic [CW-1:0] cnt_q, dlead_q, dtrail_q, ofs_q;
    logic [W-1:0]  len_q, duty_q;

    pwm_cfg_sel #(.CW(CW)) u_sel (
        .clk(clk), .rst_n(rst_n), .load(load), .auto_en(auto_en), .duty(duty),
        .th_lm_up(th_lm_up), .th_lm_dn(th_lm_dn), .th_mh_up(th_mh_up), .th_mh_dn(th_mh_dn),
        .mode_low(pwm_mode_e'(mode_low)), .mode_mid(pwm_mode_e'(mode_mid)),
        .mode_high(pwm_mode_e'(mode_high)), .mode_next(mode_next)
    );

    pwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty),
        .dead_lead(dead_lead), .dead_trail(dead_trail), .phase_ofs(phase_ofs),
        .mode_next(mode_next), .load(load), .run_q(run_q), .cnt_q(cnt_q),
        .len_q(len_q), .duty_q(duty_q), .dlead_q(dlead_q), .dtrail_q(dtrail_q),
        .ofs_q(ofs_q), .mode_q(mode_q)
    );

    pwm_edges #(.CW(CW)) u_edge (
        .mode(mode_q), .cnt(cnt_q), .len(len_q), .duty(duty_q), .dlead(dlead_q),
        .dtrail(dtrail_q), .ofs(ofs_q), .a_raw(a_raw), .b_raw(b_raw)
    );

    // Gate the drives and the strobe with the run state.
    assign pwm_a  = run_q && a_raw;
    assign pwm_b  = run_q && b_raw;
    assign pstart = run_q && (cnt_q == '0);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_a && !pwm_b && !pstart));
    // R4
    tri_a_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TRIANGLE) |-> !pwm_a);
    // R11
    start_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run_q) |=> pstart);
endmodule

// File: tb/pwm_multimode_test.sv
module pwm_multimode_test;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, auto_en = 1'b0;
    logic [CW-1:0] period = 8'd19, duty = '0, dead_lead = '0, dead_trail = '0, phase_ofs = '0;
    logic [1:0] mode_low = 2'd0, mode_mid = 2'd2, mode_high = 2'd3;
    logic [CW-1:0] th_lm_up = 8'd10, th_lm_dn = 8'd5, th_mh_up = 8'd15, th_mh_dn = 8'd12;
    logic pwm_a, pwm_b, pstart;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    pwm_multimode #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_en(auto_en), .period(period),
        .duty(duty), .dead_lead(dead_lead), .dead_trail(dead_trail), .phase_ofs(phase_ofs),
        .mode_low(mode_low), .mode_mid(mode_mid), .mode_high(mode_high),
        .th_lm_up(th_lm_up), .th_lm_dn(th_lm_dn), .th_mh_up(th_mh_up), .th_mh_dn(th_mh_dn),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .pstart(pstart)
    );

    // Fields: mode, period, duty, lead, trail, offset, a_rise, a_width, b_rise, b_width
    localparam logic [79:0] VEC [10] = '{
        {8'd0, 8'd19, 8'd8,  8'd2, 8'd3, 8'd0,  8'd0,  8'd8,  8'd10, 8'd7},  // R2
        {8'd0, 8'd19, 8'd30, 8'd2, 8'd3, 8'd0,  8'd0,  8'd20, 8'd0,  8'd0},  // R6 duty clamp
        {8'd1, 8'd19, 8'd6,  8'd2, 8'd3, 8'd0,  8'd14, 8'd6,  8'd2,  8'd9},  // R3
        {8'd1, 8'd19, 8'd20, 8'd2, 8'd3, 8'd0,  8'd0,  8'd20, 8'd0,  8'd0},  // R6 negative edge
        {8'd2, 8'd19, 8'd6,  8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd7,  8'd6},  // R4
        {8'd2, 8'd20, 8'd6,  8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd7,  8'd6},  // R4 odd gap
        {8'd3, 8'd19, 8'd8,  8'd0, 8'd0, 8'd5,  8'd0,  8'd8,  8'd5,  8'd8},  // R5
        {8'd3, 8'd19, 8'd8,  8'd0, 8'd0, 8'd16, 8'd0,  8'd8,  8'd16, 8'd8},  // R5 wrap
        {8'd3, 8'd19, 8'd20, 8'd0, 8'd0, 8'd10, 8'd0,  8'd20, 8'd10, 8'd20}, // R5 full on
        {8'd0, 8'd9,  8'd0,  8'd1, 8'd1, 8'd0,  8'd0,  8'd0,  8'd1,  8'd8}   // R2 zero duty
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_on(input int k, input int r, input int w, input int l);
        if (w == 0) return 1'b0;
        return ((k - r + l) % l) < w;
    endfunction

    task automatic wait_pstart();
        @(negedge clk);
        while (!pstart) @(negedge clk);
    endtask

    task automatic auto_step(input int d, input logic ea, input logic eb, input string req);
        duty = d[CW-1:0];
        wait_pstart();
        check(pwm_a == ea, req, pwm_a, ea);
        check(pwm_b == eb, req, pwm_b, eb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 outputs low under reset
        check(!pwm_a && !pwm_b && !pstart, "R12", {pwm_a, pwm_b, pstart}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pwm_a && !pwm_b && !pstart, "R12", {pwm_a, pwm_b, pstart}, 0);

        // Table walk, auto off so mode_low is used (R10)
        for (int v = 0; v < 10; v++) begin
            int l, ar, aw, br, bw, err;
            en = 1'b0;
            @(negedge clk);
            mode_low   = VEC[v][73:72];
            period     = VEC[v][71:64];
            duty       = VEC[v][63:56];
            dead_lead  = VEC[v][55:48];
            dead_trail = VEC[v][47:40];
            phase_ofs  = VEC[v][39:32];
            ar = VEC[v][31:24]; aw = VEC[v][23:16];
            br = VEC[v][15:8];  bw = VEC[v][7:0];
            l = int'(period) + 1;
            en = 1'b1;
            @(negedge clk);
            check(pstart == 1'b1, "R11", pstart, 1);
            err = 0;
            for (int k = 0; k < l; k++) begin
                if (k > 0) @(negedge clk);
                if (pwm_a != exp_on(k, ar, aw, l) || pwm_b != exp_on(k, br, bw, l)) begin
                    if (err == 0)
                        $display("FAIL R2-R6 vector %0d k=%0d actual=%0d expected=%0d", v, k,
                                 {pwm_a, pwm_b}, {exp_on(k, ar, aw, l), exp_on(k, br, bw, l)});
                    err++;
                end
            end
            n_chk++;
            if (err != 0) n_bad++;
            @(negedge clk);
            // R1 next period starts after exactly period+1 cycles
            check(pstart == 1'b1, "R1", pstart, 1);
        end

        // R10: auto off, duty far above thresholds still uses mode_low (normal)
        en = 1'b0; @(negedge clk);
        mode_low = 2'd0; period = 8'd19; duty = 8'd16; dead_lead = 8'd2; dead_trail = 8'd3;
        phase_ofs = 8'd0; en = 1'b1;
        wait_pstart(); wait_pstart();
        check(pwm_a && !pwm_b, "R10", {pwm_a, pwm_b}, 2);

        // R7: mid-period duty change is not used until next period
        duty = 8'd8;
        wait_pstart();
        repeat (2) @(negedge clk);
        duty = 8'd15;
        repeat (8) @(negedge clk);
        check(pwm_a == 1'b0, "R7", pwm_a, 0);
        wait_pstart();
        repeat (10) @(negedge clk);
        check(pwm_a == 1'b1, "R7", pwm_a, 1);

        // R11: disable holds outputs low, re-enable starts at once
        en = 1'b0;
        @(negedge clk);
        check(!pwm_a && !pwm_b && !pstart, "R11", {pwm_a, pwm_b, pstart}, 0);
        repeat (3) @(negedge clk);
        check(!pwm_a && !pwm_b && !pstart, "R11", {pwm_a, pwm_b, pstart}, 0);
        duty = 8'd8;
        en = 1'b1;
        @(negedge clk);
        check(pstart && pwm_a, "R11", {pstart, pwm_a}, 3);

        // Automatic switching: low=normal, mid=triangular, high=multi (offset 0)
        mode_low = 2'd0; mode_mid = 2'd2; mode_high = 2'd3;
        auto_en = 1'b1;
        auto_step(8,  1'b1, 1'b0, "R8");   // stays low
        auto_step(11, 1'b0, 1'b0, "R8");   // low -> mid
        auto_step(8,  1'b0, 1'b0, "R8");   // hysteresis holds mid
        auto_step(4,  1'b1, 1'b0, "R8");   // mid -> low
        auto_step(16, 1'b0, 1'b0, "R9");   // one step only: low -> mid
        auto_step(16, 1'b1, 1'b1, "R9");   // mid -> high
        auto_step(13, 1'b1, 1'b1, "R9");   // hysteresis holds high
        auto_step(11, 1'b0, 1'b0, "R9");   // high -> mid

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule